// File: doc/BRIEF.md
# Real-time control serial decoder

This block sits in a video encoder and receives a one-wire serial control stream that a video decoder sends once per line. The encoder uses it to follow the decoder's timing. When the block is idle, a HIGH-to-LOW transition on the line starts a frame. The block then counts fixed-length time slots from that edge and samples each slot once, close to its centre. When the last slot has arrived, it updates all decoded fields together.

The decoded status bits can replace the encoder's own values. Each override is allowed only when a master enable is set and that bit's own enable is set. The outputs are:
- the received subcarrier-PLL increment, with a flag that chooses between the received increment and internal subcarrier generation;
- a one-cycle subcarrier phase-reset pulse;
- the effective field-rate flag;
- the effective odd/even flag;
- the line-inversion flag for the R−Y colour difference signal.

The received line-PLL increment and the reserved slots are read off the line and then discarded.

Top module: `rtc_serial_decoder`

## Requirements
- R1: When idle, a frame starts at the first clock at which `rtc_i` is sampled 0 after being sampled 1. Each slot lasts `SLOT_CLKS` clocks, and the start clock is cycle 0 of slot 0. Each slot is sampled only at cycle (`SLOT_CLKS`-1)/2 of that slot; the value at any other cycle of the slot has no effect.
- R2: With the default parameters a frame is 48 slots long, laid out as follows:
  - slot 0: start;
  - slots 1–14: line-PLL increment;
  - slots 15–16: reserved;
  - slots 17–38: subcarrier increment, most significant bit first;
  - slots 39–41: reserved;
  - slot 42: sequence bit;
  - slot 43: phase-reset bit;
  - slot 44: field-rate bit;
  - slot 45: odd/even bit;
  - slot 46: colour-detect bit;
  - slot 47: trailer.
- R3: All held fields change together, in the clock at the end of the last slot. A frame that is only partly received leaves every output unchanged.
- R4: A falling edge inside a frame is treated as data. A new frame can start only after the previous frame's full length has passed, and back-to-back frames are both decoded.
- R5: `invert_ry_o` equals `pal_mode` AND the held sequence bit, so it is always 0 when `pal_mode` is 0.
- R6: `phase_rst_o` is a single-cycle pulse in the cycle after a frame completes. It is raised only if the received phase-reset bit is 1 and, at completion, `en_master`=1, `en_phase`=1 and `phase_mode`=2'b00.
- R7: `field_60hz_o` takes the held field-rate bit (1 = 60 Hz) when `en_master` and `en_field` are both 1 and at least one frame has completed since reset. Otherwise it equals `reg_field_60hz`.
- R8: `odd_even_o` takes the held odd/even bit when `en_master` and `en_oddeven` are both 1 and at least one frame has completed since reset. Otherwise it equals `int_odd_even`.
- R9: `fsc_ext_o` is 1 only when `en_master` is 1 and a frame has completed. With `en_colour`=1 it then follows the held colour-detect bit; with `en_colour`=0 it is 1. `fsc_inc_o` always shows the held 22-bit increment.
- R10: Synchronous active-high `rst` clears all held fields and any frame in progress. After reset, `fsc_inc_o`=0, `fsc_ext_o`=0, `phase_rst_o`=0, and the field-rate and odd/even outputs follow their internal inputs.
- R11: The line-PLL slots and the reserved slots have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rtc_i | input | 1 | Serial control line |
| en_master | input | 1 | Master enable for all overrides |
| en_phase | input | 1 | Enable for the phase-reset bit |
| phase_mode | input | 2 | Phase-reset mode; only 2'b00 passes the pulse |
| en_field | input | 1 | Enable for the field-rate override |
| en_oddeven | input | 1 | Enable for the odd/even override |
| en_colour | input | 1 | Enable for colour-detect source selection |
| pal_mode | input | 1 | 1 = PAL line inversion in use |
| reg_field_60hz | input | 1 | Register field rate (1 = 60 Hz) |
| int_odd_even | input | 1 | Internally generated odd/even flag |
| fsc_inc_o | output | 22 | Held subcarrier-PLL increment |
| fsc_ext_o | output | 1 | 1 = use the received increment, 0 = internal generation |
| phase_rst_o | output | 1 | Subcarrier phase-reset pulse |
| field_60hz_o | output | 1 | Effective field rate |
| odd_even_o | output | 1 | Effective odd/even flag |
| invert_ry_o | output | 1 | Current line has inverted R−Y |

## Verification
The phase-pulse assertion compares the pulse against the enable and mode inputs one cycle earlier. It therefore assumes those inputs are ordinary synchronous levels that do not change in the middle of a cycle. The stimulus changes the configuration only between frames and drives every input on the falling clock edge. The output-stability assertion assumes reset is held for at least two clocks, and the stimulus holds it for three. The serial line is assumed to be a clean, already-synchronised level. Off-centre glitches and in-frame falling edges are produced on purpose, but only at whole-clock granularity.

// File: rtl/rtc_serial_decoder.sv
module rtc_serial_decoder #(
  parameter int SLOT_CLKS = 4,
  parameter int LPLL_W    = 14,
  parameter int RSV_A_W   = 2,
  parameter int FSC_W     = 22,
  parameter int RSV_B_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rtc_i,
  input  logic             en_master,
  input  logic             en_phase,
  input  logic [1:0]       phase_mode,
  input  logic             en_field,
  input  logic             en_oddeven,
  input  logic             en_colour,
  input  logic             pal_mode,
  input  logic             reg_field_60hz,
  input  logic             int_odd_even,
  output logic [FSC_W-1:0] fsc_inc_o,
  output logic             fsc_ext_o,
  output logic             phase_rst_o,
  output logic             field_60hz_o,
  output logic             odd_even_o,
  output logic             invert_ry_o
);
  localparam int FRAME_SLOTS = 1 + LPLL_W + RSV_A_W + FSC_W + RSV_B_W + 6;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int PH_W        = $clog2(SLOT_CLKS);
  localparam int SAMPLE_PH   = (SLOT_CLKS - 1) / 2;
  localparam int LAST_PH     = SLOT_CLKS - 1;
  localparam int B_COL       = 1;
  localparam int B_OE        = 2;
  localparam int B_FF        = 3;
  localparam int B_PRST      = 4;
  localparam int B_SEQ       = 5;
  localparam int FSC_LSB     = 6 + RSV_B_W;

  logic                   rtc_d, busy, valid_q;
  logic [PH_W-1:0]        ph;
  logic [SLOT_W-1:0]      slot;
  logic [FRAME_SLOTS-1:0] shreg;
  logic [FSC_W-1:0]       fsc_q;
  logic                   seq_q, ff_q, oe_q, col_q, prst_q;
  logic                   start, done, ovr;

  assign start = !busy && rtc_d && !rtc_i;
  assign done  = busy && (slot == SLOT_W'(FRAME_SLOTS - 1)) && (ph == PH_W'(LAST_PH));

  always_ff @(posedge clk) begin
    if (rst) begin
      rtc_d   <= 1'b0;
      busy    <= 1'b0;
      ph      <= '0;
      slot    <= '0;
      shreg   <= '0;
      fsc_q   <= '0;
      seq_q   <= 1'b0;
      ff_q    <= 1'b0;
      oe_q    <= 1'b0;
      col_q   <= 1'b0;
      valid_q <= 1'b0;
      prst_q  <= 1'b0;
    end else begin
      rtc_d  <= rtc_i;
      prst_q <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        ph   <= PH_W'(1);
        slot <= '0;
      end else if (busy) begin
        if (ph == PH_W'(SAMPLE_PH))
          shreg <= {shreg[FRAME_SLOTS-2:0], rtc_i};
        if (ph == PH_W'(LAST_PH)) begin
          ph   <= '0;
          slot <= slot + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
        if (done) begin
          busy    <= 1'b0;
          valid_q <= 1'b1;
          fsc_q   <= shreg[FSC_LSB +: FSC_W];
          seq_q   <= shreg[B_SEQ];
          ff_q    <= shreg[B_FF];
          oe_q    <= shreg[B_OE];
          col_q   <= shreg[B_COL];
          prst_q  <= shreg[B_PRST] && en_master && en_phase && (phase_mode == 2'b00);
        end
      end
    end
  end

  assign ovr          = en_master && valid_q;
  assign fsc_inc_o    = fsc_q;
  assign fsc_ext_o    = ovr && (!en_colour || col_q);
  assign phase_rst_o  = prst_q;
  assign field_60hz_o = (ovr && en_field)   ? ff_q : reg_field_60hz;
  assign odd_even_o   = (ovr && en_oddeven) ? oe_q : int_odd_even;
  assign invert_ry_o  = pal_mode && seq_q;
endmodule

module rtc_serial_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        en_master,
  input logic        en_phase,
  input logic [1:0]  phase_mode,
  input logic        en_oddeven,
  input logic        pal_mode,
  input logic        reg_field_60hz,
  input logic        int_odd_even,
  input logic [21:0] fsc_inc_o,
  input logic        fsc_ext_o,
  input logic        phase_rst_o,
  input logic        field_60hz_o,
  input logic        odd_even_o,
  input logic        invert_ry_o,
  input logic        busy,
  input logic        done,
  input logic [15:0] slot_i
);
  assert_phase_gate_R6: assert property (@(posedge clk) disable iff (rst)
    phase_rst_o |-> $past(en_master && en_phase && (phase_mode == 2'b00)));
  assert_phase_single_R6: assert property (@(posedge clk) disable iff (rst)
    phase_rst_o |=> !phase_rst_o);
  assert_commit_only_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsc_inc_o) |-> $past(done));
  assert_src_master_R9: assert property (@(posedge clk) disable iff (rst)
    !en_master |-> !fsc_ext_o);
  assert_ntsc_R5: assert property (@(posedge clk) disable iff (rst)
    !pal_mode |-> !invert_ry_o);
  assert_field_reg_R7: assert property (@(posedge clk) disable iff (rst)
    !en_master |-> (field_60hz_o == reg_field_60hz));
  assert_oe_int_R8: assert property (@(posedge clk) disable iff (rst)
    (!en_master || !en_oddeven) |-> (odd_even_o == int_odd_even));
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> (slot_i >= $past(slot_i)));
endmodule

bind rtc_serial_decoder rtc_serial_decoder_chk u_chk (
  .clk(clk), .rst(rst), .en_master(en_master), .en_phase(en_phase),
  .phase_mode(phase_mode), .en_oddeven(en_oddeven), .pal_mode(pal_mode),
  .reg_field_60hz(reg_field_60hz), .int_odd_even(int_odd_even),
  .fsc_inc_o(fsc_inc_o), .fsc_ext_o(fsc_ext_o), .phase_rst_o(phase_rst_o),
  .field_60hz_o(field_60hz_o), .odd_even_o(odd_even_o),
  .invert_ry_o(invert_ry_o), .busy(busy), .done(done), .slot_i(16'(slot))
);

// File: tb/sim_rtc_serial_decoder.sv
`timescale 1ns/1ps
module sim_rtc_serial_decoder;
  localparam int SLOT = 4;
  localparam int SAMP = (SLOT - 1) / 2;
  localparam int NV   = 6;

  typedef struct packed {
    logic [21:0] fsc;
    logic [13:0] lpll;
    logic [4:0]  rx;
    logic [9:0]  cfg;
    logic [4:0]  exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{22'h2AAAAA, 14'h1234, 5'b10101, 10'b1100111101, 5'b11010},
    '{22'h155555, 14'h3FFF, 5'b01010, 10'b1100111110, 5'b00101},
    '{22'h3FFFFF, 14'h0000, 5'b11111, 10'b0100111100, 5'b00010},
    '{22'h000001, 14'h2AAA, 5'b01000, 10'b1101000011, 5'b11100},
    '{22'h200000, 14'h1555, 5'b11110, 10'b1000010000, 5'b10100},
    '{22'h0F0F0F, 14'h0F0F, 5'b01001, 10'b1100001110, 5'b11001}
  };

  logic clk = 1'b0, rst = 1'b1, rtc_i = 1'b1;
  logic en_master, en_phase, en_field, en_oddeven, en_colour, pal_mode;
  logic reg_field_60hz, int_odd_even;
  logic [1:0] phase_mode;
  logic [21:0] fsc_inc_o;
  logic fsc_ext_o, phase_rst_o, field_60hz_o, odd_even_o, invert_ry_o;
  logic [47:0] fr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_serial_decoder u0 (
    .clk(clk), .rst(rst), .rtc_i(rtc_i), .en_master(en_master),
    .en_phase(en_phase), .phase_mode(phase_mode), .en_field(en_field),
    .en_oddeven(en_oddeven), .en_colour(en_colour), .pal_mode(pal_mode),
    .reg_field_60hz(reg_field_60hz), .int_odd_even(int_odd_even),
    .fsc_inc_o(fsc_inc_o), .fsc_ext_o(fsc_ext_o), .phase_rst_o(phase_rst_o),
    .field_60hz_o(field_60hz_o), .odd_even_o(odd_even_o),
    .invert_ry_o(invert_ry_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [21:0] fsc, input logic [13:0] lpll,
                                     input logic [1:0] ra, input logic [2:0] rb,
                                     input logic [4:0] rx);
    return {1'b0, lpll, ra, fsc, rb, rx, 1'b1};
  endfunction

  task automatic set_cfg(input logic [9:0] c);
    {en_master, en_phase, phase_mode, en_field, en_oddeven, en_colour,
     pal_mode, reg_field_60hz, int_odd_even} = c;
  endtask

  task automatic drive_slots(input int lo, input int hi);
    for (int s = lo; s <= hi; s++) begin
      rtc_i = fr[47-s];
      repeat (SLOT) @(negedge clk);
    end
  endtask

  task automatic drive_centre();
    for (int s = 0; s < 48; s++) begin
      for (int j = 0; j < SLOT; j++) begin
        rtc_i = (j == SAMP) ? fr[47-s] : ((s == 0) ? 1'b0 : ~fr[47-s]);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_cfg(10'b1000111111);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 fsc_inc after reset", 32'(fsc_inc_o), 0);
    check("R10 fsc_ext after reset", 32'(fsc_ext_o), 0);
    check("R10 field follows register", 32'(field_60hz_o), 1);
    check("R10 odd_even follows internal", 32'(odd_even_o), 1);
    check("R10 phase pulse idle", 32'(phase_rst_o), 0);
    check("R10 invert idle", 32'(invert_ry_o), 0);

    // table walk: R2 R5 R6 R7 R8 R9 R11, frames back to back (R4)
    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].cfg);
      fr = mk(VEC[i].fsc, VEC[i].lpll, 2'(i), 3'(i), VEC[i].rx);
      drive_slots(0, 47);
      check($sformatf("R2 R4 fsc vec%0d", i), 32'(fsc_inc_o), 32'(VEC[i].fsc));
      check($sformatf("R9 ext vec%0d", i), 32'(fsc_ext_o), 32'(VEC[i].exp[4]));
      check($sformatf("R7 field vec%0d", i), 32'(field_60hz_o), 32'(VEC[i].exp[3]));
      check($sformatf("R8 oddeven vec%0d", i), 32'(odd_even_o), 32'(VEC[i].exp[2]));
      check($sformatf("R5 invert vec%0d", i), 32'(invert_ry_o), 32'(VEC[i].exp[1]));
      check($sformatf("R6 pulse vec%0d", i), 32'(phase_rst_o), 32'(VEC[i].exp[0]));
      if (i == NV - 1) begin
        @(negedge clk);
        check("R6 pulse lasts one cycle", 32'(phase_rst_o), 0);
      end
    end

    // R3: partial frame leaves outputs alone
    fr = mk(22'h3C3C3C, 14'h0001, 2'b00, 3'b000, 5'b00000);
    drive_slots(0, 40);
    check("R3 partial frame fsc held", 32'(fsc_inc_o), 32'h0F0F0F);
    check("R3 partial frame ext held", 32'(fsc_ext_o), 1);
    drive_slots(41, 47);
    check("R3 frame complete fsc", 32'(fsc_inc_o), 32'h3C3C3C);
    check("R3 frame complete ext", 32'(fsc_ext_o), 0);

    // R11: line-PLL and reserved content make no difference
    set_cfg(10'b1100111101);
    fr = mk(22'h123456, 14'h0000, 2'b00, 3'b000, 5'b10011);
    drive_slots(0, 47);
    fr = mk(22'h123456, 14'h3FFF, 2'b11, 3'b111, 5'b10011);
    drive_slots(0, 47);
    check("R11 fsc unaffected", 32'(fsc_inc_o), 32'h123456);
    check("R11 oddeven unaffected", 32'(odd_even_o), 1);
    check("R11 field unaffected", 32'(field_60hz_o), 0);
    check("R11 invert unaffected", 32'(invert_ry_o), 1);

    // R1: only the sample cycle of each slot matters
    set_cfg(10'b1100111101);
    fr = mk(22'h0C3A51, 14'h1A2B, 2'b01, 3'b010, 5'b11101);
    drive_centre();
    check("R1 centre sample fsc", 32'(fsc_inc_o), 32'h0C3A51);
    check("R1 centre sample pulse", 32'(phase_rst_o), 1);
    check("R1 centre sample field", 32'(field_60hz_o), 1);
    check("R1 centre sample oddeven", 32'(odd_even_o), 0);
    rtc_i = 1'b1;
    repeat (2) @(negedge clk);

    // R10: reset in the middle of a frame
    fr = mk(22'h2B2B2B, 14'h0000, 2'b00, 3'b000, 5'b00001);
    drive_slots(0, 20);
    rst = 1'b1;
    rtc_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 mid-frame reset fsc", 32'(fsc_inc_o), 0);
    check("R10 mid-frame reset ext", 32'(fsc_ext_o), 0);
    check("R10 mid-frame reset field", 32'(field_60hz_o), 0);
    drive_slots(0, 47);
    check("R4 frame after reset fsc", 32'(fsc_inc_o), 32'h2B2B2B);
    check("R9 frame after reset ext", 32'(fsc_ext_o), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule